// File: doc/BRIEF.md
# Static Memory Write Strobe Generator

This block turns single-byte write requests into timed write cycles on an asynchronous static memory bus with one chip select. A request carries a 24-bit address and one data byte. Once it is taken, the block runs one write cycle. During that cycle it drives an active-low chip-select strobe, an active-low write-enable strobe, the latched address, and the data byte with its output enable. All timing is counted in cycles of the single clock.

Each of the two strobes has its own setup count and pulse count. Both strobes share one cycle-length count. The time a strobe spends deasserted after its pulse (its hold) is whatever is left of the cycle length. A write-mode input picks the strobe that controls the write: the write-enable strobe (mode 1) or the chip-select strobe (mode 0). The data output enable turns on when the controlling strobe's setup has elapsed and stays on to the end of the cycle.

Two kinds of illegal configuration raise a flag, and the cycle still runs in a defined way:
- A pulse count of zero is run as a pulse of one cycle.
- A setup plus pulse that exceeds the cycle length makes the cycle long enough to hold both strobe windows.

A ready/valid pair on the request side takes a new write only when the block is idle or in the last cycle of the current write. Writes can therefore run back to back with no idle cycle between them.

Top module: `smw_write_strobe_gen`

## Requirements
- R1: Counting the cycles of a write as k = 0, 1, ..., L-1, where k = 0 is the first clock after acceptance, each strobe (`mem_cs_n`, `mem_we_n`) is low exactly when setup <= k < setup + pulse. It is high in the remaining hold cycles up to L-1.
- R2: The write cycle lasts L = `cfg_cycle` clocks when the configuration is legal. `busy` is 1 for all of those clocks and 0 when no write is in progress.
- R3: `req_ready` is 1 when the block is idle or at k = L-1, and 0 at every other k. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The new cycle starts with k = 0 on the next clock.
- R4: Suppose a strobe has setup 0 and setup + pulse = L, and a second write is taken at k = L-1. Then that strobe stays low without a gap across the boundary between the two cycles.
- R5: With `cfg_wr_mode` = 1 (write-enable controls the write), `mem_doe` is 1 from k = write-enable setup through k = L-1 and 0 before that, whatever the chip-select timing is.
- R6: With `cfg_wr_mode` = 0 (chip-select controls the write), `mem_doe` is 1 from k = chip-select setup through k = L-1 and 0 before that.
- R7: `mem_addr` and `mem_dout` take the request's address and data at acceptance and keep them for the whole cycle. Changes on `req_addr`/`req_data` during the cycle have no effect.
- R8: If either pulse count is 0, `cfg_pulse_err` is 1 (otherwise 0) and that strobe is driven low for exactly one cycle.
- R9: If setup + effective pulse of either strobe exceeds `cfg_cycle`, `cfg_len_err` is 1 (otherwise 0). The cycle length becomes L = max(`cfg_cycle`, chip-select setup + pulse, write-enable setup + pulse).
- R10: After reset and while idle: `mem_cs_n` = 1, `mem_we_n` = 1, `mem_doe` = 0, `busy` = 0, `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all timing counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_mode | input | 1 | 1: write-enable controls the write; 0: chip-select controls it |
| cfg_cs_setup | input | 6 | Chip-select setup count |
| cfg_cs_pulse | input | 6 | Chip-select pulse count (0 is illegal) |
| cfg_we_setup | input | 6 | Write-enable setup count |
| cfg_we_pulse | input | 6 | Write-enable pulse count (0 is illegal) |
| cfg_cycle | input | 6 | Write cycle length in clocks |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request will be taken on this edge |
| req_addr | input | 24 | Request address |
| req_data | input | 8 | Request data byte |
| mem_cs_n | output | 1 | Active-low chip-select strobe |
| mem_we_n | output | 1 | Active-low write-enable strobe |
| mem_addr | output | 24 | Latched address bus |
| mem_dout | output | 8 | Latched data byte |
| mem_doe | output | 1 | Data bus output enable |
| busy | output | 1 | Write cycle in progress |
| cfg_pulse_err | output | 1 | A pulse count is zero |
| cfg_len_err | output | 1 | Setup plus pulse exceeds the cycle length |

## Verification
The bench drives a request at a falling edge, and the request is taken at the following rising edge. Every strobe, enable, bus and handshake result for step k of a cycle is due at the k-th rising edge after the one that took the request. The bench samples each step at the falling edge after that rising edge and compares it with a window computed from the configuration. The two error flags depend only on the configuration inputs, so they are checked half a clock after the configuration is applied. The idle state is checked at the first falling edge after the L-th cycle.

// File: rtl/smw_pkg.sv
package smw_pkg;
   localparam int NUM_STB = 2;
   localparam int STB_CS  = 0;
   localparam int STB_WE  = 1;

   typedef enum logic {
      WM_CS_CTRL = 1'b0,
      WM_WE_CTRL = 1'b1
   } wmode_e;
endpackage

// File: rtl/smw_strobe_norm.sv
module smw_strobe_norm #(
   parameter int CNT_W = 6,
   localparam int LEN_W = CNT_W + 1
) (
   input  logic [CNT_W-1:0] setup_i,
   input  logic [CNT_W-1:0] pulse_i,
   output logic [LEN_W-1:0] setup_o,
   output logic [LEN_W-1:0] span_o,
   output logic             zero_pulse_o
);
   logic [LEN_W-1:0] pulse_eff;

   always_comb begin
      zero_pulse_o = (pulse_i == '0);
      pulse_eff    = zero_pulse_o ? LEN_W'(1) : LEN_W'(pulse_i);
      setup_o      = LEN_W'(setup_i);
      span_o       = setup_o + pulse_eff;
   end
endmodule

// File: rtl/smw_strobe_win.sv
module smw_strobe_win #(
   parameter int LEN_W = 7
) (
   input  logic             active_i,
   input  logic [LEN_W-1:0] cnt_i,
   input  logic [LEN_W-1:0] start_i,
   input  logic [LEN_W-1:0] stop_i,
   output logic             on_o
);
   always_comb begin
      on_o = active_i && (cnt_i >= start_i) && (cnt_i < stop_i);
   end
endmodule

// File: rtl/smw_cycle_ctr.sv
module smw_cycle_ctr #(
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] len_i,
   input  logic             req_valid_i,
   output logic             req_ready_o,
   output logic             accept_o,
   output logic             active_o,
   output logic [LEN_W-1:0] cnt_o
);
   logic last;

   always_comb begin
      last        = active_o && (cnt_o == len_i - LEN_W'(1));
      req_ready_o = !active_o || last;
      accept_o    = req_valid_i && req_ready_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         cnt_o    <= '0;
      end else if (accept_o) begin
         active_o <= 1'b1;
         cnt_o    <= '0;
      end else if (last) begin
         active_o <= 1'b0;
         cnt_o    <= '0;
      end else if (active_o) begin
         cnt_o    <= cnt_o + LEN_W'(1);
      end
   end

   assert_start_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> (active_o && cnt_o == '0));

   assert_count_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> (cnt_o < len_i));

   assert_no_take_midcycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !last) |=> (cnt_o == $past(cnt_o) + LEN_W'(1)));
endmodule

// File: rtl/smw_write_strobe_gen.sv
module smw_write_strobe_gen #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 6,
   localparam int LEN_W = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_mode,
   input  logic [CNT_W-1:0]  cfg_cs_setup,
   input  logic [CNT_W-1:0]  cfg_cs_pulse,
   input  logic [CNT_W-1:0]  cfg_we_setup,
   input  logic [CNT_W-1:0]  cfg_we_pulse,
   input  logic [CNT_W-1:0]  cfg_cycle,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_doe,
   output logic              busy,
   output logic              cfg_pulse_err,
   output logic              cfg_len_err
);
   import smw_pkg::*;

   if (ADDR_W < 1) begin : g_chk_addr
      $error("smw_write_strobe_gen: ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("smw_write_strobe_gen: DATA_W must be at least 1");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("smw_write_strobe_gen: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] setup_raw [NUM_STB];
   logic [CNT_W-1:0] pulse_raw [NUM_STB];
   logic [LEN_W-1:0] setup_n   [NUM_STB];
   logic [LEN_W-1:0] span_n    [NUM_STB];
   logic             zero_p    [NUM_STB];
   logic             stb_on    [NUM_STB];
   logic             over_len  [NUM_STB];

   logic             accept;
   logic             active;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] cyc_len;
   logic [LEN_W-1:0] doe_start;
   wmode_e           wmode;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_comb begin
      setup_raw[STB_CS] = cfg_cs_setup;
      pulse_raw[STB_CS] = cfg_cs_pulse;
      setup_raw[STB_WE] = cfg_we_setup;
      pulse_raw[STB_WE] = cfg_we_pulse;
   end

   for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
      smw_strobe_norm #(.CNT_W(CNT_W)) u_norm (
         .setup_i      (setup_raw[i]),
         .pulse_i      (pulse_raw[i]),
         .setup_o      (setup_n[i]),
         .span_o       (span_n[i]),
         .zero_pulse_o (zero_p[i])
      );
      smw_strobe_win #(.LEN_W(LEN_W)) u_win (
         .active_i (active),
         .cnt_i    (cnt),
         .start_i  (setup_n[i]),
         .stop_i   (span_n[i]),
         .on_o     (stb_on[i])
      );
      assign over_len[i] = span_n[i] > LEN_W'(cfg_cycle);
   end

   always_comb begin
      cyc_len = LEN_W'(cfg_cycle);
      for (int i = 0; i < NUM_STB; i++) begin
         if (span_n[i] > cyc_len) cyc_len = span_n[i];
      end
      cfg_pulse_err = 1'b0;
      cfg_len_err   = 1'b0;
      for (int i = 0; i < NUM_STB; i++) begin
         cfg_pulse_err = cfg_pulse_err | zero_p[i];
         cfg_len_err   = cfg_len_err   | over_len[i];
      end
   end

   smw_cycle_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .len_i       (cyc_len),
      .req_valid_i (req_valid),
      .req_ready_o (req_ready),
      .accept_o    (accept),
      .active_o    (active),
      .cnt_o       (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
      end
   end

   always_comb begin
      wmode     = wmode_e'(cfg_wr_mode);
      doe_start = (wmode == WM_WE_CTRL) ? setup_n[STB_WE] : setup_n[STB_CS];
      mem_doe   = active && (cnt >= doe_start);
      mem_cs_n  = !stb_on[STB_CS];
      mem_we_n  = !stb_on[STB_WE];
      mem_addr  = addr_q;
      mem_dout  = data_q;
      busy      = active;
   end

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_cs_n && mem_we_n && !mem_doe && req_ready));

   assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(accept)) |-> ($stable(mem_addr) && $stable(mem_dout)));

   assert_doe_with_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr_mode && !mem_we_n) |-> mem_doe);

   assert_doe_with_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cfg_wr_mode && !mem_cs_n) |-> mem_doe);

   assert_doe_to_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_doe && !req_ready) |=> mem_doe);
endmodule

// File: tb/smw_write_strobe_gen_tb.sv
module smw_write_strobe_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_mode = 1'b1;
   logic [5:0]  cfg_cs_setup = '0, cfg_cs_pulse = 6'd1;
   logic [5:0]  cfg_we_setup = '0, cfg_we_pulse = 6'd1;
   logic [5:0]  cfg_cycle = 6'd1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic        mem_cs_n, mem_we_n, mem_doe, busy;
   logic        cfg_pulse_err, cfg_len_err;
   logic [23:0] mem_addr;
   logic [7:0]  mem_dout;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   smw_write_strobe_gen u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_mode(cfg_wr_mode),
      .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
      .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse),
      .cfg_cycle(cfg_cycle), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .mem_cs_n(mem_cs_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_doe(mem_doe), .busy(busy), .cfg_pulse_err(cfg_pulse_err),
      .cfg_len_err(cfg_len_err)
   );

   task automatic chk(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int span(input int s, input int p);
      return s + ((p == 0) ? 1 : p);
   endfunction

   function automatic int cyc_len();
      int l = cfg_cycle;
      if (span(cfg_cs_setup, cfg_cs_pulse) > l) l = span(cfg_cs_setup, cfg_cs_pulse);
      if (span(cfg_we_setup, cfg_we_pulse) > l) l = span(cfg_we_setup, cfg_we_pulse);
      return l;
   endfunction

   task automatic set_cfg(input bit m, input int css, input int csp,
                          input int wes, input int wep, input int cyc);
      cfg_wr_mode  = m;
      cfg_cs_setup = 6'(css);
      cfg_cs_pulse = 6'(csp);
      cfg_we_setup = 6'(wes);
      cfg_we_pulse = 6'(wep);
      cfg_cycle    = 6'(cyc);
   endtask

   task automatic check_idle(input string req);
      chk(int'(mem_cs_n), 1, req, "idle cs_n");
      chk(int'(mem_we_n), 1, req, "idle we_n");
      chk(int'(mem_doe), 0, req, "idle doe");
      chk(int'(busy), 0, req, "idle busy");
      chk(int'(req_ready), 1, req, "idle ready");
   endtask

   // Call at a falling edge with req_valid=1 and the request on req_addr/req_data.
   task automatic do_cycle(input logic [23:0] a, input logic [7:0] d,
                           input bit keep, input logic [23:0] na, input logic [7:0] nd,
                           input string t_stb, input string t_len);
      int l = cyc_len();
      int css = cfg_cs_setup, wes = cfg_we_setup;
      int cse = span(cfg_cs_setup, cfg_cs_pulse);
      int wee = span(cfg_we_setup, cfg_we_pulse);
      int ds = cfg_wr_mode ? wes : css;
      string tdoe = cfg_wr_mode ? "R5" : "R6";
      @(posedge clk);
      for (int k = 0; k < l; k++) begin
         @(negedge clk);
         chk(int'(mem_cs_n), (k >= css && k < cse) ? 0 : 1, t_stb, $sformatf("cs_n k=%0d", k));
         chk(int'(mem_we_n), (k >= wes && k < wee) ? 0 : 1, t_stb, $sformatf("we_n k=%0d", k));
         chk(int'(mem_doe), (k >= ds) ? 1 : 0, tdoe, $sformatf("doe k=%0d", k));
         chk(int'(busy), 1, t_len, $sformatf("busy k=%0d", k));
         chk(int'(req_ready), (k == l - 1) ? 1 : 0, "R3", $sformatf("ready k=%0d", k));
         chk(int'(mem_addr), int'(a), "R7", $sformatf("addr k=%0d", k));
         chk(int'(mem_dout), int'(d), "R7", $sformatf("dout k=%0d", k));
         if (k == 0) begin
            if (keep) begin
               req_addr = na;
               req_data = nd;
            end else begin
               req_valid = 1'b0;
               req_addr  = ~a;
               req_data  = ~d;
            end
         end
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R10");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R10");
   endtask

   task automatic t_we_ctrl;
      set_cfg(1'b1, 1, 5, 2, 3, 8);
      @(negedge clk);
      chk(int'(cfg_pulse_err), 0, "R8", "pulse_err legal");
      chk(int'(cfg_len_err), 0, "R9", "len_err legal");
      req_valid = 1'b1; req_addr = 24'hA5_1234; req_data = 8'h3C;
      do_cycle(24'hA5_1234, 8'h3C, 1'b0, '0, '0, "R1", "R2");
      @(negedge clk);
      check_idle("R2");
   endtask

   task automatic t_cs_ctrl;
      set_cfg(1'b0, 3, 2, 1, 5, 7);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 24'h00_0F0F; req_data = 8'hC3;
      do_cycle(24'h00_0F0F, 8'hC3, 1'b0, '0, '0, "R1", "R2");
      @(negedge clk);
      check_idle("R6");
   endtask

   task automatic t_back_to_back;
      set_cfg(1'b1, 0, 4, 1, 2, 4);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 24'h11_2233; req_data = 8'h44;
      do_cycle(24'h11_2233, 8'h44, 1'b1, 24'h55_6677, 8'h88, "R4", "R2");
      do_cycle(24'h55_6677, 8'h88, 1'b0, '0, '0, "R4", "R2");
      @(negedge clk);
      check_idle("R3");
   endtask

   task automatic t_zero_pulse;
      set_cfg(1'b1, 0, 5, 2, 0, 6);
      @(negedge clk);
      chk(int'(cfg_pulse_err), 1, "R8", "pulse_err zero pulse");
      chk(int'(cfg_len_err), 0, "R8", "len_err zero pulse");
      req_valid = 1'b1; req_addr = 24'hFF_0001; req_data = 8'h01;
      do_cycle(24'hFF_0001, 8'h01, 1'b0, '0, '0, "R8", "R2");
      @(negedge clk);
      check_idle("R8");
   endtask

   task automatic t_overrun;
      set_cfg(1'b0, 3, 6, 1, 2, 5);
      @(negedge clk);
      chk(int'(cfg_len_err), 1, "R9", "len_err overrun");
      chk(int'(cfg_pulse_err), 0, "R9", "pulse_err overrun");
      req_valid = 1'b1; req_addr = 24'h80_0000; req_data = 8'h7E;
      do_cycle(24'h80_0000, 8'h7E, 1'b0, '0, '0, "R9", "R9");
      @(negedge clk);
      check_idle("R9");
   endtask

   initial begin
      t_reset();
      t_we_ctrl();
      t_cs_ctrl();
      t_back_to_back();
      t_zero_pulse();
      t_overrun();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule